// File: doc/BRIEF.md
# Mid-Range Four-Way Chip-Select Decoder

This block turns a 20-bit memory address into four active-low chip-selects for one relocatable window of memory. Two control registers set up the window. The size register holds a one-hot code that picks a total window of 8K, 16K, 32K, 64K, 128K, 256K or 512K. The base register holds the upper address bits of the window start. The window is cut into four equal, adjacent quarters. Each quarter drives one select, with the lowest quarter on select 0 and the highest on select 3.

Both registers are written and read through a simple register port that is addressed by an offset. A select can only become active after both registers have been written since reset. Software must keep the window clear of other chip-select regions; the block does not check for overlap. The size register also carries a small ready-mode code, which goes out on its own pins. Its other spare bits are stored and read back, and they have no other effect.

The selects are registered. The value present at a clock edge reflects the address and strobe that were sampled at that same edge. The address path is plain and has no handshake: a new address may be presented on every cycle.

Top module: `midcs_top`

## Requirements
- R1: After reset all four selects are high (inactive), the ready-mode output is 0, and the selects stay high until both the size register (offset 0xA8) and the base register (offset 0xA6) have been written, whatever the address.
- R2: The size code sits in size-register bits 14..8. If only bit 8+k is set (k = 0..6), the total window is 8K shifted left by k, and each select covers one quarter of that.
- R3: Base-register bits 15..9 give address bits 19..13 of the window start, and the lower start bits are zero. An address hits when its bits 19..(13+k) equal the matching base bits. Base bits below the window size have no effect.
- R4: On a hit, only select q goes low, where q = (address − window start) / (window size / 4). This equals address bits (12+k)..(11+k). Select 0 is the lowest quarter.
- R5: When the address-valid strobe is low, all selects are high on the next cycle.
- R6: At most one select is low at any time.
- R7: If size bits 14..8 hold no bit set, or more than one bit set, no select goes low.
- R8: A read at offset 0xA8 or 0xA6 returns all 16 stored bits of that register unchanged. A read at any other offset, or with the read strobe low, returns 0. A write at any other offset changes neither register.
- R9: The ready-mode output always equals bits 2..0 of the stored size register.
- R10: The selects are registered. The address and strobe sampled at edge t set the selects from edge t onward. A register write at edge t applies to addresses sampled from edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Memory address to decode |
| addr_vld | input | 1 | Address valid strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ofs | input | 8 | Register offset in the control block |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cs_n | output | 4 | Active-low selects, one per quarter |
| rdy_mode | output | 3 | Ready-mode code from the size register |

## Verification
Two situations are hard to reach from the ports. One is a window that is armed but decoded with only one register written. The other is a base whose low bits lie inside a large window. The bench writes one register at a time and probes a matching address after each write. It also programs a base that is not aligned to the window, then checks that the window snaps down to the aligned start. Each of the seven sizes is swept over the full 1M space on a 1K grid, with a varying offset inside each 1K step, at two bases. The explicit window and quarter edges are added to each sweep, so every quarter boundary is hit exactly.

// File: rtl/midcs_pkg.sv
package midcs_pkg;
  // Smallest total window is 2**MIN_WIN_LOG2 bytes (8K).
  localparam int unsigned MIN_WIN_LOG2 = 13;
  // Number of one-hot size codes (8K .. 512K).
  localparam int unsigned SIZE_CODES   = 7;
  // Width of the ready-mode code held in the low size-register bits.
  localparam int unsigned RDY_BITS     = 3;
endpackage

// File: rtl/midcs_regs.sv
module midcs_regs #(
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned REG_W    = 16,
  parameter logic [7:0]  SIZE_OFS = 8'hA8,
  parameter logic [7:0]  BASE_OFS = 8'hA6,
  parameter int unsigned SZ_FW    = 7,
  parameter int unsigned SZ_LSB   = 8,
  parameter int unsigned BS_FW    = 7,
  parameter int unsigned BS_LSB   = 9,
  parameter int unsigned RDY_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [OFS_W-1:0] ofs,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [SZ_FW-1:0] size_fld,
  output logic [BS_FW-1:0] base_fld,
  output logic [RDY_W-1:0] rdy,
  output logic             armed
);
  localparam logic [OFS_W-1:0] SZ_O = OFS_W'(SIZE_OFS);
  localparam logic [OFS_W-1:0] BS_O = OFS_W'(BASE_OFS);

  logic [REG_W-1:0] size_q, base_q;
  logic             size_set, base_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= '0;
      base_q   <= '0;
      size_set <= 1'b0;
      base_set <= 1'b0;
    end else if (wr) begin
      if (ofs == SZ_O) begin
        size_q   <= wdata;
        size_set <= 1'b1;
      end
      if (ofs == BS_O) begin
        base_q   <= wdata;
        base_set <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && ofs == SZ_O) rdata = size_q;
    if (rd && ofs == BS_O) rdata = base_q;
  end

  assign size_fld = size_q[SZ_LSB +: SZ_FW];
  assign base_fld = base_q[BS_LSB +: BS_FW];
  assign rdy      = size_q[RDY_W-1:0];
  assign armed    = size_set & base_set;
endmodule

// File: rtl/midcs_dec.sv
module midcs_dec #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned MIN_LOG2 = 13,
  parameter int unsigned NCODE    = 7,
  parameter int unsigned SEL_W    = 2
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NCODE-1:0]           size_fld,
  input  logic [ADDR_W-MIN_LOG2-1:0] base_fld,
  output logic                       hit,
  output logic [SEL_W-1:0]           idx
);
  localparam int unsigned BS_FW = ADDR_W - MIN_LOG2;

  logic [ADDR_W-1:0] base_addr;
  logic [NCODE-1:0]  hit_v;
  logic [SEL_W-1:0]  idx_v [NCODE];

  assign base_addr = {base_fld, {MIN_LOG2{1'b0}}};

  // One comparator and one quarter-index slice per window size.
  for (genvar k = 0; k < NCODE; k++) begin : g_size
    localparam int unsigned LO = MIN_LOG2 + k;
    assign hit_v[k] = (addr[ADDR_W-1:LO] == base_addr[ADDR_W-1:LO]);
    assign idx_v[k] = addr[LO-1 -: SEL_W];
  end

  logic             hit_any;
  logic [SEL_W-1:0] idx_any;

  always_comb begin
    hit_any = 1'b0;
    idx_any = '0;
    for (int k = 0; k < NCODE; k++) begin
      if (size_fld[k]) begin
        hit_any = hit_any | hit_v[k];
        idx_any = idx_any | idx_v[k];
      end
    end
  end

  // Only a legal one-hot size code may produce a hit.
  assign hit = hit_any & $onehot(size_fld);
  assign idx = idx_any;

  if (BS_FW < NCODE) begin : g_bad_cfg
    initial $error("window codes exceed address width");
  end
endmodule

// File: rtl/midcs_sel.sv
module midcs_sel #(
  parameter int unsigned NSEL  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] idx,
  output logic [NSEL-1:0]  cs_n
);
  logic [NSEL-1:0] dec_n;

  for (genvar j = 0; j < NSEL; j++) begin : g_line
    assign dec_n[j] = !(en && idx == SEL_W'(j));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n <= '1;
    else        cs_n <= dec_n;
  end
endmodule

// File: rtl/midcs_top.sv
module midcs_top #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned REG_W    = 16,
  parameter logic [7:0]  SIZE_OFS = 8'hA8,
  parameter logic [7:0]  BASE_OFS = 8'hA6,
  parameter int unsigned MIN_LOG2 = midcs_pkg::MIN_WIN_LOG2,
  parameter int unsigned NCODE    = midcs_pkg::SIZE_CODES,
  parameter int unsigned SZ_LSB   = 8,
  parameter int unsigned BS_LSB   = 9,
  parameter int unsigned NSEL     = 4,
  parameter int unsigned RDY_W    = midcs_pkg::RDY_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic             addr_vld,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [OFS_W-1:0] reg_ofs,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [NSEL-1:0]  cs_n,
  output logic [RDY_W-1:0] rdy_mode
);
  localparam int unsigned SEL_W = $clog2(NSEL);
  localparam int unsigned BS_FW = ADDR_W - MIN_LOG2;

  logic [NCODE-1:0] size_fld;
  logic [BS_FW-1:0] base_fld;
  logic             armed, hit;
  logic [SEL_W-1:0] idx;

  midcs_regs #(
    .OFS_W(OFS_W), .REG_W(REG_W), .SIZE_OFS(SIZE_OFS), .BASE_OFS(BASE_OFS),
    .SZ_FW(NCODE), .SZ_LSB(SZ_LSB), .BS_FW(BS_FW), .BS_LSB(BS_LSB),
    .RDY_W(RDY_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .ofs(reg_ofs),
    .wdata(reg_wdata), .rdata(reg_rdata), .size_fld(size_fld),
    .base_fld(base_fld), .rdy(rdy_mode), .armed(armed)
  );

  midcs_dec #(
    .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .NCODE(NCODE), .SEL_W(SEL_W)
  ) u_dec (
    .addr(addr), .size_fld(size_fld), .base_fld(base_fld),
    .hit(hit), .idx(idx)
  );

  midcs_sel #(.NSEL(NSEL), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .en(armed & addr_vld & hit),
    .idx(idx), .cs_n(cs_n)
  );
endmodule

// File: rtl/midcs_chk.sv
module midcs_chk #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned REG_W    = 16,
  parameter logic [7:0]  SIZE_OFS = 8'hA8,
  parameter logic [7:0]  BASE_OFS = 8'hA6,
  parameter int unsigned NCODE    = 7,
  parameter int unsigned SZ_LSB   = 8,
  parameter int unsigned NSEL     = 4,
  parameter int unsigned RDY_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic             addr_vld,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [OFS_W-1:0] reg_ofs,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [NSEL-1:0]  cs_n,
  input logic [RDY_W-1:0] rdy_mode
);
  localparam logic [OFS_W-1:0] SZ_O = OFS_W'(SIZE_OFS);
  localparam logic [OFS_W-1:0] BS_O = OFS_W'(BASE_OFS);

  // Shadow copies built only from port activity.
  logic [REG_W-1:0] size_sh, base_sh;
  logic             seen_s, seen_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_sh <= '0; base_sh <= '0; seen_s <= 1'b0; seen_b <= 1'b0;
    end else if (reg_wr) begin
      if (reg_ofs == SZ_O) begin size_sh <= reg_wdata; seen_s <= 1'b1; end
      if (reg_ofs == BS_O) begin base_sh <= reg_wdata; seen_b <= 1'b1; end
    end
  end

  a_r1_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !(seen_s && seen_b) |-> cs_n == '1);

  a_r5_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> cs_n == '1);

  a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot(size_sh[SZ_LSB +: NCODE]) |=> cs_n == '1);

  a_r8_size_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_ofs == SZ_O) |-> reg_rdata == size_sh);

  a_r8_base_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_ofs == BS_O) |-> reg_rdata == base_sh);

  a_r9_ready_code: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_mode == size_sh[RDY_W-1:0]);
endmodule

bind midcs_top midcs_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .REG_W(REG_W), .SIZE_OFS(SIZE_OFS),
  .BASE_OFS(BASE_OFS), .NCODE(NCODE), .SZ_LSB(SZ_LSB), .NSEL(NSEL),
  .RDY_W(RDY_W)
) u_chk (.*);

// File: tb/tb_midcs_top.sv
module tb_midcs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        addr_vld = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_ofs = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  cs_n;
  logic [2:0]  rdy_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  midcs_top dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_vld(addr_vld),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_n(cs_n),
    .rdy_mode(rdy_mode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] o, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ofs = o; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] o, logic [15:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_ofs = o;
    #1 check(req, reg_rdata, exp);
    reg_rd = 1'b0;
  endtask

  // Drive one address, let one edge register it, sample at the next negedge.
  task automatic probe(string req, logic [19:0] a, logic v, logic [3:0] exp);
    @(negedge clk);
    addr = a; addr_vld = v;
    @(negedge clk);
    check(req, cs_n, exp);
  endtask

  function automatic logic [3:0] model(int k, int unsigned base, int unsigned a);
    int unsigned win = 32'd8192 << k;
    int unsigned st  = (base / win) * win;
    if (a / win != st / win) return 4'hF;
    return ~(4'b0001 << ((a - st) / (win / 4)));
  endfunction

  task automatic sweep(int k, int unsigned base);
    int unsigned win = 32'd8192 << k;
    int unsigned st  = (base / win) * win;
    wr(8'hA8, 16'(1 << (8 + k)) | 16'h8025);
    wr(8'hA6, 16'((base >> 13) << 9) | 16'h01A5);
    for (int i = 0; i < 1024; i++) begin
      int unsigned a = i * 1024 + ((i * 331) & 1023);
      probe("R2/R3/R4 sweep", 20'(a), 1'b1, model(k, base, a));
    end
    for (int q = 0; q <= 4; q++) begin
      int unsigned e = st + q * (win / 4);
      if (e < 32'h100000) probe("R4 quarter start", 20'(e), 1'b1, model(k, base, e));
      if (e > 0) probe("R4 quarter end", 20'(e - 1), 1'b1, model(k, base, e - 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cs_n", cs_n, 4'hF);
    check("R1 reset rdy", rdy_mode, 3'd0);
    rd("R8 reset size read", 8'hA8, 16'h0);
    rst_n = 1'b1;
    probe("R1 no regs", 20'h00000, 1'b1, 4'hF);
    wr(8'hA8, 16'h0101);
    probe("R1 size only", 20'h00000, 1'b1, 4'hF);
    wr(8'hA6, 16'h0000);
    probe("R1 armed q0", 20'h00000, 1'b1, 4'b1110);
    probe("R1 armed q3", 20'h01800, 1'b1, 4'b0111);
    check("R9 rdy code", rdy_mode, 3'd1);

    // R10: write then use on the following address.
    wr(8'hA6, 16'(20'h40000 >> 13) << 9);
    probe("R10 new base hit", 20'h40800, 1'b1, 4'b1101);
    probe("R10 old base miss", 20'h00800, 1'b1, 4'hF);

    // R5: strobe low inside the window.
    probe("R5 strobe low", 20'h40000, 1'b0, 4'hF);
    probe("R5 strobe back", 20'h41000, 1'b1, 4'b1011);

    // R3: unaligned base, 32K window snaps to 0x10000.
    wr(8'hA8, 16'h0400);
    wr(8'hA6, 16'(20'h14000 >> 13) << 9);
    probe("R3 unaligned low", 20'h10000, 1'b1, 4'b1110);
    probe("R3 unaligned top", 20'h17FFF, 1'b1, 4'b0111);
    probe("R3 unaligned past", 20'h18000, 1'b1, 4'hF);

    // R7: illegal size codes.
    wr(8'hA8, 16'h0000);
    probe("R7 zero code", 20'h10000, 1'b1, 4'hF);
    wr(8'hA8, 16'h0C00);
    probe("R7 two bits", 20'h10000, 1'b1, 4'hF);

    // R8 / R9: readback and ignored offsets.
    wr(8'hA8, 16'hF5FD);
    wr(8'hA6, 16'h3C5A);
    wr(8'hA0, 16'h1234);
    rd("R8 size read", 8'hA8, 16'hF5FD);
    rd("R8 base read", 8'hA6, 16'h3C5A);
    rd("R8 other read", 8'hA4, 16'h0);
    @(negedge clk);
    reg_rd = 1'b0; reg_ofs = 8'hA8;
    #1 check("R8 no strobe", reg_rdata, 16'h0);
    check("R9 rdy code 5", rdy_mode, 3'd5);

    // R2/R3/R4: every size at two bases.
    for (int k = 0; k < 7; k++) begin
      sweep(k, 0);
      sweep(k, 32'hB6000);
    end
    check("R9 rdy after sweep", rdy_mode, 3'd5);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule